// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port on a simple APB-style register bus with byte-wide data. Each line has a direction bit and an output data bit. The pads are driven through `pad_out` and `pad_oe`, and the pad inputs are read back through a two-stage synchroniser.

The output data is not reached through a single register address. It is reached through a window of 256 word addresses. In that window, address bits [9:2] act as a per-line mask. A write changes only the masked lines, and a read returns only the masked lines. Software can therefore change one line with a single store and no read-modify-write. A written value reaches a line only while that line is already an output, so a value written to an input line is lost.

A small phase machine tracks the bus handshake. It has three states:

- `PH_IDLE`: no transfer.
- `PH_SETUP`: `psel` high and `penable` low were seen.
- `PH_ACCESS`: the access phase.

The transitions are:

- IDLE→SETUP: on `psel && !penable`.
- SETUP→ACCESS: on `psel && penable`. This is the only transition that commits a transfer, and it takes one cycle with no wait states.
- ACCESS→SETUP: on a back-to-back setup.
- ACCESS→IDLE and SETUP→IDLE: otherwise.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset every line is an input: `pad_oe` is 0x00, `pad_out` is 0x00, and the direction register reads 0x00.
- R2: Byte offset 0x400 holds the direction register. Bit n = 1 makes line n an output. `pad_oe` follows this register, and a read of 0x400 returns it.
- R3: A write to the data window (offsets 0x000–0x3FC) updates output bit n only when address bit n+2 is 1. All other output bits keep their value.
- R4: A data write to a line that is an input at the time of the write leaves that line's output bit unchanged. Switching the line to an output afterwards drives the old value, not the value written while it was an input.
- R5: A read of the data window returns, for each line whose address bit n+2 is 1, the output bit if the line is an output, or the synchronised pad input if it is an input. Lines whose mask bit is 0 read as 0.
- R6: A change on `pad_in` becomes visible to data reads after two clock edges. A read whose access phase falls one edge after the change returns the old value.
- R7: The identification bytes read back as follows: 0xFE0 → 0x61, 0xFE4 → 0x10, 0xFE8 → 0x04, 0xFEC → 0x00. Together these form the 32-bit value 0x00041061.
- R8: Any other offset (for example 0x404 or 0x800) reads as 0x00, and writes to it change neither `pad_out` nor `pad_oe`.
- R9: A transfer commits only in an access phase that directly follows a setup phase. `prdata` is 0x00 whenever no read access phase is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Select of this port |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in the read access phase |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Output data to pads |
| pad_oe | output | 8 | Per-line output enable |

## Verification
The bench aims at the masked write while some lines are still inputs. A design that ignored the direction gate would drive a stale 1 the moment the line became an output. A design that ignored the mask would clobber neighbouring lines.

The bench also mixes output and input lines in a single read, which exposes a read path that returns the output register instead of the pin value. It changes `pad_in` in the same cycle a read starts, so a design with one synchroniser stage (or none) returns the new value too early.

Finally, the bench issues an access with `penable` already high and no setup phase, and writes to unmapped offsets. A decoder or phase tracker that is too permissive would then change the pads.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;

    localparam logic [31:0] PORT_ID_WORD = 32'h0004_1061;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bus_phase.sv
module gpio_bus_phase
    import gpio_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic access_ok
);
    bus_phase_e state_q;
    bus_phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = PH_IDLE;
        unique case (state_q)
            PH_IDLE:   state_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            PH_SETUP:  state_d = (psel && penable) ? PH_ACCESS : PH_IDLE;
            PH_ACCESS: state_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        access_ok = 1'b0;
        unique case (state_q)
            PH_SETUP:  access_ok = psel && penable;
            PH_IDLE,
            PH_ACCESS: access_ok = 1'b0;
            default:   access_ok = 1'b0;
        endcase
    end

    // R9: an access only ever follows a setup cycle on the bus
    assert_access_after_setup_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        access_ok |-> $past(psel && !penable)
    );
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mask_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  rdata
);
    localparam int WAW = AW - 2;
    localparam logic [WAW-1:0]  DIR_WORD = WAW'(1) << N;
    localparam logic [AW-5:0]   ID_BLOCK = {(AW-4){1'b1}} - 1'b1;

    logic         data_hit;
    logic         dir_hit;
    logic         id_hit;
    logic [N-1:0] mask;
    logic [N-1:0] pin_val;
    logic [7:0]   id_byte;

    assign data_hit = (addr[AW-1:N+2] == '0);
    assign dir_hit  = (addr[AW-1:2] == DIR_WORD);
    assign id_hit   = (addr[AW-1:4] == ID_BLOCK);
    assign mask     = addr[N+1:2];
    assign pin_val  = (dir_q & out_q) | (~dir_q & pin_in);
    assign id_byte  = PORT_ID_WORD[8*addr[3:2] +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 dir_q <= '0;
        else if (wr_stb && dir_hit) dir_q <= wdata;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                out_q[g] <= 1'b0;
            else if (wr_stb && data_hit && mask[g] && dir_q[g])
                out_q[g] <= wdata[g];
        end

        // R4: a write while the line is an input leaves its output bit alone
        assert_input_write_ignored_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            (wr_stb && !dir_q[g]) |=> $stable(out_q[g])
        );

        // R3: a write whose mask bit is clear leaves the line alone
        assert_unmasked_kept_R3: assert property (
            @(posedge clk) disable iff (!rst_n)
            (wr_stb && data_hit && !addr[g+2]) |=> $stable(out_q[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (data_hit)     rdata = pin_val & mask;
            else if (dir_hit) rdata = dir_q;
            else if (id_hit)  rdata = N'(id_byte);
        end
    end

    // R2: a direction write takes the written byte
    assert_dir_write_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_stb && dir_hit) |=> (dir_q == $past(wdata))
    );
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
    parameter int N_LINES = 8,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [N_LINES-1:0] pwdata,
    output logic [N_LINES-1:0] prdata,
    input  logic [N_LINES-1:0] pad_in,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_oe
);
    logic               access_ok;
    logic               wr_stb;
    logic               rd_stb;
    logic [N_LINES-1:0] pin_sync;

    gpio_bus_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .access_ok (access_ok)
    );

    assign wr_stb = access_ok && pwrite;
    assign rd_stb = access_ok && !pwrite;

    gpio_sync #(.W(N_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.N(N_LINES), .AW(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .addr   (paddr),
        .wdata  (pwdata),
        .pin_in (pin_sync),
        .dir_q  (pad_oe),
        .out_q  (pad_out),
        .rdata  (prdata)
    );

    // R9: read data is quiet outside a read access phase
    assert_quiet_rdata_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(psel && penable && !pwrite) |-> (prdata == '0)
    );
endmodule

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_ev;

    always #2.5 clk = ~clk;

    gpio_masked_port dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [7:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [7:0] exp, string req);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        penable = 1'b1;
        #1 -> rd_ev;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // monitor: pops one expected byte per read access phase
    initial begin
        forever begin
            @(rd_ev);
            check(tag_q.pop_front(), prdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0x00 expected 0x01");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R9 idle prdata", prdata, 8'h00);
        bus_read(12'h400, 8'h00, "R1 dir");

        pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, 8'hA5, "R5 all inputs");
        bus_read(12'h014, 8'h05, "R5 masked lines 0,2");

        bus_write(12'h3FC, 8'hFF);
        check("R4 input write", pad_out, 8'h00);

        bus_write(12'h400, 8'h0F);
        check("R2 pad_oe", pad_oe, 8'h0F);
        check("R4 stale value", pad_out, 8'h00);
        bus_read(12'h400, 8'h0F, "R2 dir readback");

        bus_write(12'h3FC, 8'hFF);
        check("R3 R4 full write", pad_out, 8'h0F);
        bus_write(12'h008, 8'h00);
        check("R3 line1 only", pad_out, 8'h0D);
        bus_write(12'h3C0, 8'h00);
        check("R3 input lines masked", pad_out, 8'h0D);
        bus_read(12'h3FC, 8'hAD, "R5 mixed");

        pad_in = 8'h5A;
        bus_read(12'h3FC, 8'hAD, "R6 one edge");
        bus_read(12'h3FC, 8'h5D, "R6 two edges");

        bus_read(12'hFE0, 8'h61, "R7 id0");
        bus_read(12'hFE4, 8'h10, "R7 id1");
        bus_read(12'hFE8, 8'h04, "R7 id2");
        bus_read(12'hFEC, 8'h00, "R7 id3");

        bus_read(12'h800, 8'h00, "R8 read 0x800");
        bus_read(12'h404, 8'h00, "R8 read 0x404");
        bus_write(12'h800, 8'hFF);
        bus_write(12'h404, 8'hFF);
        check("R8 pad_out", pad_out, 8'h0D);
        check("R8 pad_oe", pad_oe, 8'h0F);

        // R9: access phase without a setup phase must not commit
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h3FC; pwdata = 8'h00;
        @(negedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check("R9 no setup write", pad_out, 8'h0D);
        check("R9 idle prdata after", prdata, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule